// File: doc/BRIEF.md
# Guarded Memory Window Bus Adapter

This block connects a word-oriented register bus to two internal memories. One is an instruction store and the other is a data store. Each memory is reached through its own address window. A request is carried out only while the surrounding compute unit reports that it is idle.

While the unit is busy, a request touches no memory and reads back zero. The block also raises an illegal-access fatal flag for that request. While the unit is locked, requests are zeroed in the same way but raise no flag.

The host can see only the lower three quarters of the data store. Requests that fall into the hidden quarter, or outside both windows, complete with a bus error. A write that does not enable all four bytes is refused with a bus error. Every request gets exactly one response, one cycle after it is presented.

Top module: `memwin_guard`

## Requirements
- R1: While idle, a full-word write to a byte offset from 0x4000 to 0x4FFC stores the word in the instruction store (word index = offset bits 11:2). A later read of the same offset returns that word with rsp_err low.
- R2: While idle, offsets 0x8000 to 0x8BFC reach the first 768 words of the data store for full-word reads and writes.
- R3: A request accepted at a clock edge produces rsp_valid high for exactly the following cycle. No response appears in a cycle after an edge with no request.
- R4: When unit_state is 2'b01 (busy), a request returns rsp_rdata 0 and rsp_err 0, and does not modify either store. The block pulses illegal_access with that response.
- R5: When unit_state[1] is 1 (locked), a request returns rsp_rdata 0, rsp_err 0 and illegal_access 0, and does not modify either store.
- R6: While idle, offsets 0x8C00 to 0x8FFC (the hidden quarter of the data store) return rsp_err 1 and rsp_rdata 0, and a write there changes no visible word.
- R7: While idle, an offset outside both windows returns rsp_err 1 and rsp_rdata 0.
- R8: While idle, a write whose byte enable is not 4'b1111 returns rsp_err 1 and leaves the addressed word unchanged.
- R9: After reset, rsp_valid, rsp_err and illegal_access are all 0.
- R10: illegal_access is high only together with rsp_valid, and never together with rsp_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Byte offset of the request |
| req_wdata_i | input | 32 | Write data |
| req_be_i | input | 4 | Byte enables for a write |
| unit_state_i | input | 2 | 00 idle, 01 busy, 1x locked |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data; 0 for writes and refused requests |
| rsp_err_o | output | 1 | Bus error for decode misses and partial writes |
| illegal_access_o | output | 1 | Fatal flag for a request made while busy |

## Verification
The assertions watch several properties on every cycle. They check the one-cycle request-to-response relation and the zeroed, flagged response to busy requests. They also check the silent response to locked requests, the error on partial writes, and that the fatal flag never appears without a response or alongside an error.

Storage effects can only be shown by the bench's write-then-read sequences. These cover data that persists at both ends of each window, writes dropped while busy or locked, and partial writes that leave a word intact. They also cover the hidden data quarter never aliasing onto visible words.

// File: rtl/memwin_guard.sv
module memwin_guard #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BE_W = DATA_W / 8,
  parameter int IMEM_WORDS = 1024,
  parameter int DMEM_WORDS = 1024,
  parameter int DMEM_VISIBLE = 768,
  parameter logic [ADDR_W-1:0] IMEM_BASE = 16'h4000,
  parameter logic [ADDR_W-1:0] DMEM_BASE = 16'h8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [1:0]        unit_state_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              illegal_access_o
);

  localparam int OFF_LSB = $clog2(BE_W);
  localparam int I_IDX_W = $clog2(IMEM_WORDS);
  localparam int D_IDX_W = $clog2(DMEM_WORDS);
  localparam int I_TOP = OFF_LSB + I_IDX_W;
  localparam int D_TOP = OFF_LSB + D_IDX_W;

  logic [DATA_W-1:0] imem [IMEM_WORDS];
  logic [DATA_W-1:0] dmem [DMEM_WORDS];

  logic [I_IDX_W-1:0] i_idx;
  logic [D_IDX_W-1:0] d_idx;
  logic i_hit, d_hit, d_vis, is_idle, is_busy, full_word;
  logic acc_ok, wr_ok, dec_err;

  assign i_idx     = req_addr_i[OFF_LSB +: I_IDX_W];
  assign d_idx     = req_addr_i[OFF_LSB +: D_IDX_W];
  assign i_hit     = req_addr_i[ADDR_W-1:I_TOP] == IMEM_BASE[ADDR_W-1:I_TOP];
  assign d_hit     = req_addr_i[ADDR_W-1:D_TOP] == DMEM_BASE[ADDR_W-1:D_TOP];
  assign d_vis     = d_hit && (int'(d_idx) < DMEM_VISIBLE);
  assign is_idle   = unit_state_i == 2'b00;
  assign is_busy   = unit_state_i == 2'b01;
  assign full_word = &req_be_i;

  assign acc_ok  = req_valid_i && is_idle && (i_hit || d_vis);
  assign wr_ok   = acc_ok && req_write_i && full_word;
  assign dec_err = req_valid_i && is_idle &&
                   (!(i_hit || d_vis) || (req_write_i && !full_word));

  always_ff @(posedge clk_i) begin
    if (wr_ok && i_hit) imem[i_idx] <= req_wdata_i;
    if (wr_ok && d_vis) dmem[d_idx] <= req_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o      <= 1'b0;
      rsp_err_o        <= 1'b0;
      illegal_access_o <= 1'b0;
      rsp_rdata_o      <= '0;
    end else begin
      rsp_valid_o      <= req_valid_i;
      rsp_err_o        <= dec_err;
      illegal_access_o <= req_valid_i && is_busy;
      if (acc_ok && !req_write_i)
        rsp_rdata_o <= i_hit ? imem[i_idx] : dmem[d_idx];
      else
        rsp_rdata_o <= '0;
    end
  end

endmodule

// File: rtl/memwin_guard_chk.sv
module memwin_guard_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [BE_W-1:0]   req_be_i,
  input logic [1:0]        unit_state_i,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              rsp_err_o,
  input logic              illegal_access_o
);

  a_r3_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r3_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r4_busy_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && unit_state_i == 2'b01) |=>
      (illegal_access_o && !rsp_err_o && rsp_rdata_o == '0));

  a_r5_locked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && unit_state_i[1]) |=>
      (!illegal_access_o && !rsp_err_o && rsp_rdata_o == '0));

  a_r8_partial_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && unit_state_i == 2'b00 && !(&req_be_i)) |=>
      rsp_err_o);

  a_r10_fatal_with_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_access_o |-> (rsp_valid_o && !rsp_err_o));

endmodule

bind memwin_guard memwin_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_be_i(req_be_i),
  .unit_state_i(unit_state_i), .rsp_valid_o(rsp_valid_o),
  .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
  .illegal_access_o(illegal_access_o)
);

// File: tb/memwin_guard_bench.sv
module memwin_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic [1:0]  unit_state = '0;
  logic        rsp_valid, rsp_err, illegal_access;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  memwin_guard u_memwin_guard (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .unit_state_i(unit_state), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .rsp_err_o(rsp_err), .illegal_access_o(illegal_access)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [1:0]  st;
    logic [31:0] exp_d;
    logic        exp_err;
    logic        exp_fat;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h4000, 32'hA1A1A1A1, 4'hF, 2'b00, 32'h0,        1'b0, 1'b0}, // R1
    '{1'b0, 16'h4000, 32'h0,        4'hF, 2'b00, 32'hA1A1A1A1, 1'b0, 1'b0}, // R1
    '{1'b1, 16'h4FFC, 32'h5A5A0001, 4'hF, 2'b00, 32'h0,        1'b0, 1'b0}, // R1
    '{1'b0, 16'h4FFC, 32'h0,        4'hF, 2'b00, 32'h5A5A0001, 1'b0, 1'b0}, // R1
    '{1'b1, 16'h8000, 32'hD0D00000, 4'hF, 2'b00, 32'h0,        1'b0, 1'b0}, // R2
    '{1'b0, 16'h8000, 32'h0,        4'hF, 2'b00, 32'hD0D00000, 1'b0, 1'b0}, // R2
    '{1'b1, 16'h8BFC, 32'h0BFC0BFC, 4'hF, 2'b00, 32'h0,        1'b0, 1'b0}, // R2
    '{1'b0, 16'h8BFC, 32'h0,        4'hF, 2'b00, 32'h0BFC0BFC, 1'b0, 1'b0}, // R2
    '{1'b0, 16'h8C00, 32'h0,        4'hF, 2'b00, 32'h0,        1'b1, 1'b0}, // R6
    '{1'b1, 16'h8C00, 32'hFFFFFFFF, 4'hF, 2'b00, 32'h0,        1'b1, 1'b0}, // R6
    '{1'b0, 16'h8000, 32'h0,        4'hF, 2'b00, 32'hD0D00000, 1'b0, 1'b0}, // R6
    '{1'b0, 16'h2000, 32'h0,        4'hF, 2'b00, 32'h0,        1'b1, 1'b0}, // R7
    '{1'b1, 16'h4000, 32'h00000000, 4'h3, 2'b00, 32'h0,        1'b1, 1'b0}, // R8
    '{1'b0, 16'h4000, 32'h0,        4'hF, 2'b00, 32'hA1A1A1A1, 1'b0, 1'b0}, // R8
    '{1'b0, 16'h4000, 32'h0,        4'hF, 2'b01, 32'h0,        1'b0, 1'b1}, // R4
    '{1'b1, 16'h4000, 32'h12345678, 4'hF, 2'b01, 32'h0,        1'b0, 1'b1}, // R4
    '{1'b0, 16'h4000, 32'h0,        4'hF, 2'b00, 32'hA1A1A1A1, 1'b0, 1'b0}, // R4
    '{1'b0, 16'h8BFC, 32'h0,        4'hF, 2'b10, 32'h0,        1'b0, 1'b0}, // R5
    '{1'b1, 16'h8BFC, 32'h00000000, 4'hF, 2'b11, 32'h0,        1'b0, 1'b0}, // R5
    '{1'b0, 16'h8BFC, 32'h0,        4'hF, 2'b00, 32'h0BFC0BFC, 1'b0, 1'b0}, // R5
    '{1'b0, 16'hC000, 32'h0,        4'hF, 2'b00, 32'h0,        1'b1, 1'b0}  // R7
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_addr = v.addr;
    req_wdata = v.wdata; req_be = v.be; unit_state = v.st;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R9 rsp_err after reset", 32'(rsp_err), 32'd0);
    check("R9 illegal after reset", 32'(illegal_access), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i]);
      check($sformatf("R3 vec%0d rsp_valid", i), 32'(rsp_valid), 32'd1);
      check($sformatf("vec%0d rdata", i), rsp_rdata, VEC[i].exp_d);
      check($sformatf("vec%0d err", i), 32'(rsp_err), 32'(VEC[i].exp_err));
      check($sformatf("R10 vec%0d fatal", i), 32'(illegal_access), 32'(VEC[i].exp_fat));
    end

    @(negedge clk);
    check("R3 no response without request", 32'(rsp_valid), 32'd0);
    check("R10 no fatal without request", 32'(illegal_access), 32'd0);

    issue('{1'b0, 16'h2000, 32'h0, 4'hF, 2'b01, 32'h0, 1'b0, 1'b0});
    check("R4 busy unmapped fatal", 32'(illegal_access), 32'd1);
    check("R10 busy unmapped no err", 32'(rsp_err), 32'd0);

    issue('{1'b1, 16'h8BFC, 32'hCAFEF00D, 4'hE, 2'b00, 32'h0, 1'b0, 1'b0});
    check("R8 partial dmem err", 32'(rsp_err), 32'd1);
    issue('{1'b0, 16'h8BFC, 32'h0, 4'hF, 2'b00, 32'h0, 1'b0, 1'b0});
    check("R8 dmem word kept", rsp_rdata, 32'h0BFC0BFC);

    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h4800;
    req_wdata = 32'h0000BEEF; req_be = 4'hF; unit_state = 2'b00;
    @(negedge clk);
    req_write = 1'b0;
    check("R3 back-to-back write rsp", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 back-to-back read data", rsp_rdata, 32'h0000BEEF);

    done = 1'b1;
    finish_run();
  end

endmodule